// File: doc/BRIEF.md
# Accumulator ALU with Per-Operation Flag Update

This block is the arithmetic and flag core of a small 8-bit accumulator processor. A decoded operation code selects one of fifteen operations. The byte operations are compare, increment, decrement, four one-place rotates and three carry-only operations. The word operations are add, subtract, compare, increment and decrement on 16-bit register pairs.

The result and its write-enable are combinational. They are valid in the same cycle the operation code and operands are presented. The zero (Z), auxiliary carry (AC) and carry (CY) flags live in registers inside the block. A flag is loaded on the rising clock edge only when the flag-enable input is high and the operation's own update mask names that flag. The other flags keep their values.

Rotate-through-carry and the carry invert read the registered CY. AC means the carry out of bit 3 for additions and the borrow into bit 4 for subtractions. For word operations it is taken from the low nibble of the low byte. Z reflects the full result width of the operation, including the discarded difference of a compare.

Top module: `alu8_core`

## Requirements
- R1: Byte compare (op 0) forms op_a_i[7:0] minus op_b_i[7:0] and never asserts res_we_o. With flag_en_i high it loads Z (difference is zero), AC (low nibble of A below low nibble of B) and CY (A below B).
- R2: Word add (op 1) drives result_o with op_a_i + op_b_i modulo 2^16 and asserts res_we_o. It loads CY with the carry out of bit 15, AC with the carry out of bit 3, and Z when the 16-bit sum is zero.
- R3: Word subtract (op 2) drives result_o with op_a_i - op_b_i modulo 2^16 and asserts res_we_o. It loads CY with the borrow out of bit 15, AC with the borrow into bit 4, and Z when the difference is zero.
- R4: Word compare (op 3) loads the same three flags as word subtract and never asserts res_we_o.
- R5: Byte increment (op 4) and byte decrement (op 5) drive result_o with op_a_i[7:0] plus or minus one modulo 256, upper byte zero, and assert res_we_o. They load Z and AC and leave CY unchanged. AC is set when the increment carries out of bit 3, or when the decrement borrows into bit 4.
- R6: Word increment (op 6) and word decrement (op 7) drive result_o with op_a_i plus or minus one modulo 2^16 and assert res_we_o. They change no flag.
- R7: Rotate right (op 8) moves bit 0 into bit 7 and CY. Rotate left (op 9) moves bit 7 into bit 0 and CY. Both write the byte with the upper byte zero and leave Z and AC unchanged.
- R8: Rotate right through carry (op 10) puts the old CY in bit 7 and bit 0 in CY. Rotate left through carry (op 11) puts the old CY in bit 0 and bit 7 in CY. Both write the byte with the upper byte zero and leave Z and AC unchanged.
- R9: Set carry (op 12), clear carry (op 13) and invert carry (op 14) change only CY and never assert res_we_o.
- R10: Flags change only on a rising clock edge with flag_en_i high. The new values appear on z_o, ac_o and cy_o after that edge.
- R11: While rst_n is low all three flags read 0. Op 15 is a no-operation: it never asserts res_we_o and changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, flags load on rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| op_i | input | 4 | Operation code |
| op_a_i | input | 16 | Accumulator or register pair; byte ops use bits 7:0 |
| op_b_i | input | 16 | Second operand; byte ops use bits 7:0 |
| flag_en_i | input | 1 | Permits the flag update of this cycle |
| result_o | output | 16 | Operation result |
| res_we_o | output | 1 | Result should be written back |
| z_o | output | 1 | Registered zero flag |
| ac_o | output | 1 | Registered auxiliary carry flag |
| cy_o | output | 1 | Registered carry flag |

## Verification
The result and write-enable depend only on the present inputs and the registered flags. They are due in the same cycle, so the bench checks them one nanosecond after driving the inputs at the falling edge. Flag values are due one rising edge later. The bench checks them one nanosecond after that edge against a model that applies each operation's mask only when the flag-enable is high. Constrained random operations with a fixed seed are mixed with directed wrap, borrow, nibble-boundary, disabled-enable and no-operation cases.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int NIB_W = 4;

    typedef enum logic [3:0] {
        OP_CMPB = 4'd0,
        OP_ADDW = 4'd1,
        OP_SUBW = 4'd2,
        OP_CMPW = 4'd3,
        OP_INCB = 4'd4,
        OP_DECB = 4'd5,
        OP_INCW = 4'd6,
        OP_DECW = 4'd7,
        OP_RORB = 4'd8,
        OP_ROLB = 4'd9,
        OP_RORC = 4'd10,
        OP_ROLC = 4'd11,
        OP_SETC = 4'd12,
        OP_CLRC = 4'd13,
        OP_NOTC = 4'd14,
        OP_NOP  = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic ac;
        logic cy;
    } flags_t;
endpackage

// File: rtl/alu8_decode.sv
module alu8_decode
    import alu8_pkg::*;
(
    input  alu_op_e op,
    output logic    we,
    output logic    is_word,
    output flags_t  mask
);
    always_comb begin
        we      = 1'b0;
        is_word = 1'b0;
        mask    = '0;
        unique case (op)
            OP_CMPB: mask = '{z: 1'b1, ac: 1'b1, cy: 1'b1};
            OP_ADDW, OP_SUBW: begin
                we = 1'b1; is_word = 1'b1;
                mask = '{z: 1'b1, ac: 1'b1, cy: 1'b1};
            end
            OP_CMPW: begin
                is_word = 1'b1;
                mask = '{z: 1'b1, ac: 1'b1, cy: 1'b1};
            end
            OP_INCB, OP_DECB: begin
                we = 1'b1;
                mask = '{z: 1'b1, ac: 1'b1, cy: 1'b0};
            end
            OP_INCW, OP_DECW: begin
                we = 1'b1; is_word = 1'b1;
            end
            OP_RORB, OP_ROLB, OP_RORC, OP_ROLC: begin
                we = 1'b1;
                mask = '{z: 1'b0, ac: 1'b0, cy: 1'b1};
            end
            OP_SETC, OP_CLRC, OP_NOTC: mask = '{z: 1'b0, ac: 1'b0, cy: 1'b1};
            OP_NOP: ;
        endcase
    end
endmodule

// File: rtl/alu8_byte_unit.sv
module alu8_byte_unit
    import alu8_pkg::*;
#(
    parameter int BW = 8
) (
    input  alu_op_e       op,
    input  logic [BW-1:0] a,
    input  logic [BW-1:0] b,
    input  logic          cy_in,
    output logic [BW-1:0] res,
    output flags_t        fl
);
    logic [BW:0] diff;
    assign diff = {1'b0, a} - {1'b0, b};

    always_comb begin
        res   = a;
        fl.cy = cy_in;
        fl.ac = 1'b0;
        unique case (op)
            OP_CMPB: begin
                res   = diff[BW-1:0];
                fl.cy = diff[BW];
                fl.ac = a[NIB_W-1:0] < b[NIB_W-1:0];
            end
            OP_INCB: begin
                res   = a + 1'b1;
                fl.ac = &a[NIB_W-1:0];
            end
            OP_DECB: begin
                res   = a - 1'b1;
                fl.ac = ~|a[NIB_W-1:0];
            end
            OP_RORB: begin
                res   = {a[0], a[BW-1:1]};
                fl.cy = a[0];
            end
            OP_ROLB: begin
                res   = {a[BW-2:0], a[BW-1]};
                fl.cy = a[BW-1];
            end
            OP_RORC: begin
                res   = {cy_in, a[BW-1:1]};
                fl.cy = a[0];
            end
            OP_ROLC: begin
                res   = {a[BW-2:0], cy_in};
                fl.cy = a[BW-1];
            end
            OP_SETC: fl.cy = 1'b1;
            OP_CLRC: fl.cy = 1'b0;
            OP_NOTC: fl.cy = ~cy_in;
            default: ;
        endcase
        fl.z = (res == '0);
    end
endmodule

// File: rtl/alu8_word_unit.sv
module alu8_word_unit
    import alu8_pkg::*;
#(
    parameter int WW = 16
) (
    input  alu_op_e       op,
    input  logic [WW-1:0] a,
    input  logic [WW-1:0] b,
    output logic [WW-1:0] res,
    output flags_t        fl
);
    logic [WW:0]    sum;
    logic [WW:0]    diff;
    logic [NIB_W:0] nib_sum;

    assign sum     = {1'b0, a} + {1'b0, b};
    assign diff    = {1'b0, a} - {1'b0, b};
    assign nib_sum = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]};

    always_comb begin
        res   = a;
        fl.cy = 1'b0;
        fl.ac = 1'b0;
        unique case (op)
            OP_ADDW: begin
                res   = sum[WW-1:0];
                fl.cy = sum[WW];
                fl.ac = nib_sum[NIB_W];
            end
            OP_SUBW, OP_CMPW: begin
                res   = diff[WW-1:0];
                fl.cy = diff[WW];
                fl.ac = a[NIB_W-1:0] < b[NIB_W-1:0];
            end
            OP_INCW: res = a + 1'b1;
            OP_DECW: res = a - 1'b1;
            default: ;
        endcase
        fl.z = (res == '0);
    end
endmodule

// File: rtl/alu8_flag_reg.sv
module alu8_flag_reg
    import alu8_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   en,
    input  flags_t mask,
    input  flags_t nxt,
    output flags_t q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            if (mask.z)  q.z  <= nxt.z;
            if (mask.ac) q.ac <= nxt.ac;
            if (mask.cy) q.cy <= nxt.cy;
        end
    end

    a_r10_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(q));
    a_r11_masked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> $stable(q));
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [3:0]            op_i,
    input  logic [2*BYTE_W-1:0]   op_a_i,
    input  logic [2*BYTE_W-1:0]   op_b_i,
    input  logic                  flag_en_i,
    output logic [2*BYTE_W-1:0]   result_o,
    output logic                  res_we_o,
    output logic                  z_o,
    output logic                  ac_o,
    output logic                  cy_o
);
    localparam int WORD_W = 2 * BYTE_W;

    alu_op_e           op;
    logic              is_word;
    flags_t            mask, bfl, wfl, nxt, fq;
    logic [BYTE_W-1:0] bres;
    logic [WORD_W-1:0] wres;

    assign op = alu_op_e'(op_i);

    alu8_decode u_dec (.op(op), .we(res_we_o), .is_word(is_word), .mask(mask));

    alu8_byte_unit #(.BW(BYTE_W)) u_byte (
        .op(op), .a(op_a_i[BYTE_W-1:0]), .b(op_b_i[BYTE_W-1:0]),
        .cy_in(fq.cy), .res(bres), .fl(bfl)
    );

    alu8_word_unit #(.WW(WORD_W)) u_word (
        .op(op), .a(op_a_i), .b(op_b_i), .res(wres), .fl(wfl)
    );

    assign nxt      = is_word ? wfl : bfl;
    assign result_o = is_word ? wres : {{(WORD_W-BYTE_W){1'b0}}, bres};

    alu8_flag_reg u_flags (
        .clk(clk), .rst_n(rst_n), .en(flag_en_i), .mask(mask), .nxt(nxt), .q(fq)
    );

    assign z_o  = fq.z;
    assign ac_o = fq.ac;
    assign cy_o = fq.cy;

    a_r1_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd0 || op_i == 4'd3) |-> !res_we_o);
    a_r5_incdec_keeps_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4 || op_i == 4'd5) |=> $stable(cy_o));
    a_r6_word_step_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd6 || op_i == 4'd7) |=> $stable({z_o, ac_o, cy_o}));
    a_r8_rorc_uses_old_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd10) |-> (result_o[BYTE_W-1] == cy_o));
    a_r9_setc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd12 && flag_en_i) |=> cy_o);
    a_r2_addw_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1) |-> (res_we_o && result_o == op_a_i + op_b_i));
endmodule

// File: tb/tb_alu8_core.sv
`timescale 1ns/1ps
module tb_alu8_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = 4'd15;
    logic [15:0] a = '0, b = '0;
    logic        fen = 1'b0;
    logic [15:0] result;
    logic        we, z, ac, cy;

    int checks = 0, fails = 0;
    logic mz = 1'b0, mac = 1'b0, mcy = 1'b0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    alu8_core dut (
        .clk(clk), .rst_n(rst_n), .op_i(op), .op_a_i(a), .op_b_i(b), .flag_en_i(fen),
        .result_o(result), .res_we_o(we), .z_o(z), .ac_o(ac), .cy_o(cy)
    );

    function automatic string req_of(input logic [3:0] o);
        case (o)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4, 4'd5: return "R5";
            4'd6, 4'd7: return "R6";
            4'd8, 4'd9: return "R7";
            4'd10, 4'd11: return "R8";
            4'd12, 4'd13, 4'd14: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic void model(input logic [3:0] o, input logic [15:0] x, y,
                                  input logic zi, aci, cyi,
                                  output logic [15:0] r, output logic w,
                                  output logic zo, aco, cyo);
        int t;
        zo = zi; aco = aci; cyo = cyi; w = 1'b0; r = 'x;
        case (o)
            4'd0: begin
                t = int'(x[7:0]) - int'(y[7:0]);
                zo = (t == 0); cyo = (t < 0); aco = (x[3:0] < y[3:0]);
            end
            4'd1: begin
                t = int'(x) + int'(y); r = 16'(t); w = 1'b1;
                zo = (r == 0); cyo = (t > 65535); aco = (int'(x[3:0]) + int'(y[3:0]) > 15);
            end
            4'd2, 4'd3: begin
                t = int'(x) - int'(y); w = (o == 4'd2); r = 16'(t);
                zo = (t == 0); cyo = (t < 0); aco = (x[3:0] < y[3:0]);
            end
            4'd4: begin
                r = {8'h00, 8'(x[7:0] + 8'd1)}; w = 1'b1;
                zo = (r == 0); aco = (x[3:0] == 4'hF);
            end
            4'd5: begin
                r = {8'h00, 8'(x[7:0] - 8'd1)}; w = 1'b1;
                zo = (r == 0); aco = (x[3:0] == 4'h0);
            end
            4'd6: begin r = x + 16'd1; w = 1'b1; end
            4'd7: begin r = x - 16'd1; w = 1'b1; end
            4'd8: begin r = {8'h00, x[0], x[7:1]}; w = 1'b1; cyo = x[0]; end
            4'd9: begin r = {8'h00, x[6:0], x[7]}; w = 1'b1; cyo = x[7]; end
            4'd10: begin r = {8'h00, cyi, x[7:1]}; w = 1'b1; cyo = x[0]; end
            4'd11: begin r = {8'h00, x[6:0], cyi}; w = 1'b1; cyo = x[7]; end
            4'd12: cyo = 1'b1;
            4'd13: cyo = 1'b0;
            4'd14: cyo = ~cyi;
            default: ;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] o, input logic [15:0] x, y, input logic en);
        logic [15:0] er;
        logic ew, ez, eac, ecy;
        string rq;
        @(negedge clk);
        op = o; a = x; b = y; fen = en;
        rq = req_of(o);
        model(o, x, y, mz, mac, mcy, er, ew, ez, eac, ecy);
        #1;
        chk(rq, "write enable", {15'd0, we}, {15'd0, ew});
        if (ew) chk(rq, "result", result, er);
        @(posedge clk);
        #1;
        if (en) begin mz = ez; mac = eac; mcy = ecy; end
        chk(en ? rq : "R10", "flags", {13'd0, z, ac, cy}, {13'd0, mz, mac, mcy});
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "reset flags", {13'd0, z, ac, cy}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        // directed corners
        step(4'd12, 16'h0000, 16'h0000, 1'b1);   // R9 set carry
        step(4'd0, 16'h0055, 16'h0055, 1'b1);    // R1 equal compare
        step(4'd0, 16'h0010, 16'h0001, 1'b1);    // R1 nibble borrow
        step(4'd1, 16'hFFFF, 16'h0001, 1'b1);    // R2 wrap to zero
        step(4'd2, 16'h0000, 16'h0001, 1'b1);    // R3 borrow
        step(4'd3, 16'h1234, 16'h1234, 1'b1);    // R4 equal
        step(4'd12, 16'h0, 16'h0, 1'b1);
        step(4'd4, 16'h00FF, 16'h0, 1'b1);       // R5 inc wrap, CY kept
        step(4'd5, 16'h0000, 16'h0, 1'b1);       // R5 dec wrap
        step(4'd6, 16'hFFFF, 16'h0, 1'b1);       // R6
        step(4'd7, 16'h0000, 16'h0, 1'b1);       // R6
        step(4'd8, 16'h0001, 16'h0, 1'b1);       // R7
        step(4'd9, 16'h0080, 16'h0, 1'b1);       // R7
        step(4'd13, 16'h0, 16'h0, 1'b1);
        step(4'd10, 16'h0081, 16'h0, 1'b1);      // R8
        step(4'd11, 16'h0080, 16'h0, 1'b1);      // R8
        step(4'd14, 16'h0, 16'h0, 1'b1);         // R9 invert
        step(4'd13, 16'h0, 16'h0, 1'b0);         // R10 disabled
        step(4'd15, 16'h0000, 16'h0000, 1'b1);   // R11 no-op
        for (int i = 0; i < 3000; i++) begin
            step(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom),
                 ($urandom_range(0, 7) != 0));
        end
        finished = 1;
        summary();
    end
endmodule